// File: doc/BRIEF.md
# Paged Program Counter Loader

This block holds the 13-bit program counter of a small accumulator-style processor. It also holds the 5-bit page latch that provides the upper address bits. On every clock edge, which is one instruction cycle, the counter takes exactly one action. It can clear to zero, load a jump or call target, load its low byte from the datapath, or step forward by one.

The upper counter bits cannot be written directly. They only arrive from the page latch, in one of two ways:
- A low-byte load copies all five latch bits into PC[12:8].
- A jump or call copies only the top two latch bits into PC[12:11], because the instruction literal already supplies PC[10:0].

A low-byte load either stores a byte or adds a byte to the current low byte. The add form implements table lookups through a computed branch. Its sum never carries into the page bits, so a table that runs past a 256-word boundary wraps back to the start of the same page.

Instruction decode, the ALU and program memory sit outside the block. The ALU result and the jump literal arrive on plain input ports.

Top module: `pgpc_loader`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both `pc` and `lat_q` become zero.
- R2: A sampled `clr` sets `pc` to zero on the next edge. It overrides every other PC action and leaves `lat_q` unchanged.
- R3: With no `clr`, `jmp` or `lo_wr`, `pc` advances by one per cycle. A carry out of bit 7 moves into bit 8, and 0x1FFF wraps to 0x0000.
- R4: A low-byte store (`lo_wr`=1, `lo_add`=0, no `jmp`/`clr`) makes `pc[7:0]` equal `lo_data` and `pc[12:8]` equal `lat_q[4:0]`.
- R5: A low-byte add (`lo_wr`=1, `lo_add`=1) makes `pc[7:0]` equal (old `pc[7:0]` + `lo_data`) mod 256 and `pc[12:8]` equal `lat_q[4:0]`. No carry from the sum reaches the page bits.
- R6: A jump (`jmp`=1, no `clr`) makes `pc[10:0]` equal `jmp_tgt` and `pc[12:11]` equal `lat_q[4:3]`.
- R7: When `jmp` and `lo_wr` are both asserted, the jump wins and `lo_wr` has no effect on `pc`. This input combination is illegal and is used only to check the priority.
- R8: `lat_we` loads `lat_din` into `lat_q` on the next edge. A PC load in the same cycle uses the latch value from before that write.
- R9: `lat_q` changes only through `lat_we` or reset. Jumps, low-byte loads, increments and `clr` leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset for the counter and the latch |
| clr | input | 1 | Synchronous counter clear, highest priority |
| lo_wr | input | 1 | Load the low byte from the datapath |
| lo_add | input | 1 | With `lo_wr`: add `lo_data` to the low byte instead of storing it |
| lo_data | input | 8 | ALU result for a low-byte load |
| jmp | input | 1 | Jump or call request |
| jmp_tgt | input | 11 | Literal target carried by the jump or call |
| lat_we | input | 1 | Write enable of the page latch |
| lat_din | input | 5 | New page latch value |
| pc | output | 13 | Current program counter; the low byte is also the readable register value |
| lat_q | output | 5 | Current page latch |

## Verification
A behavioural model in the bench predicts `pc` and `lat_q` for every cycle and checks both. Directed cycles come first:
- Runs of increments that cross a page boundary and the top of the address space separate a 13-bit carry from an 8-bit one.
- A store followed by an add whose sum passes 0xFF shows whether the page bits come from the latch or from a carry.
- Jumps made with latch values whose low three bits differ from their top two show whether only two latch bits reach the counter.
- Latch writes in the same cycle as loads show that the old latch value is used.

After that, a long pseudo-random mix of all actions, clears and latch writes checks that the actions do not interfere with each other.

// File: rtl/pgl_pkg.sv
package pgl_pkg;

    // One action per instruction cycle, listed from lowest to highest priority
    typedef enum logic [1:0] {
        ACT_INC = 2'd0,
        ACT_LOW = 2'd1,
        ACT_JMP = 2'd2,
        ACT_CLR = 2'd3
    } pc_act_e;

endpackage

// File: rtl/pgl_arbiter.sv
module pgl_arbiter
    import pgl_pkg::*;
(
    input  logic    clr,
    input  logic    lo_wr,
    input  logic    jmp,
    output pc_act_e act
);

    // Fixed priority: clear, then jump, then low-byte load, else step
    always_comb begin
        if (clr) begin
            act = ACT_CLR;
        end else if (jmp) begin
            act = ACT_JMP;
        end else if (lo_wr) begin
            act = ACT_LOW;
        end else begin
            act = ACT_INC;
        end
    end

    always_comb begin
        if (jmp && !clr) begin
            assert (act == ACT_JMP) else $error("AST_JMP_OVER_LOW"); // R7
        end
    end

endmodule

// File: rtl/pgl_latch.sv
module pgl_latch #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LAT_W-1:0] din,
    output logic [LAT_W-1:0] q
);

    typedef struct packed {
        logic [LAT_W-1:0] val;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we)) |-> $stable(q)); // R9

    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we)) |-> (q == $past(din))); // R8

endmodule

// File: rtl/pgl_nextpc.sv
module pgl_nextpc
    import pgl_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int LIT_W = 11
) (
    input  pc_act_e               act,
    input  logic [PC_W-1:0]       pc_cur,
    input  logic [PC_W-LO_W-1:0]  lat,
    input  logic                  lo_add,
    input  logic [LO_W-1:0]       lo_data,
    input  logic [LIT_W-1:0]      tgt,
    output logic [PC_W-1:0]       pc_nxt
);

    localparam int HI_W  = PC_W - LO_W;
    localparam int JHI_W = PC_W - LIT_W;

    logic [PC_W-1:0] inc_pc;
    logic [PC_W-1:0] low_pc;
    logic [PC_W-1:0] jmp_pc;
    logic [LO_W-1:0] low_byte;

    // Plain step: full-width add, wraps at the top of the address space
    assign inc_pc = pc_cur + PC_W'(1);

    // Low-byte load: the sum is truncated to LO_W, so it never carries into the page
    always_comb begin
        if (lo_add) begin
            low_byte = LO_W'(pc_cur[LO_W-1:0] + lo_data);
        end else begin
            low_byte = lo_data;
        end
    end

    assign low_pc = {lat[HI_W-1:0], low_byte};

    // Jump: the literal covers the low LIT_W bits; top latch bits fill the rest
    generate
        if (JHI_W > 0) begin : g_paged_jmp
            assign jmp_pc = {lat[HI_W-1 -: JHI_W], tgt};
        end else begin : g_flat_jmp
            assign jmp_pc = tgt[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_CLR: pc_nxt = '0;
            ACT_JMP: pc_nxt = jmp_pc;
            ACT_LOW: pc_nxt = low_pc;
            default: pc_nxt = inc_pc;
        endcase
    end

endmodule

// File: rtl/pgpc_loader.sv
module pgpc_loader
    import pgl_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int LIT_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 lo_wr,
    input  logic                 lo_add,
    input  logic [LO_W-1:0]      lo_data,
    input  logic                 jmp,
    input  logic [LIT_W-1:0]     jmp_tgt,
    input  logic                 lat_we,
    input  logic [PC_W-LO_W-1:0] lat_din,
    output logic [PC_W-1:0]      pc,
    output logic [PC_W-LO_W-1:0] lat_q
);

    localparam int HI_W  = PC_W - LO_W;
    localparam int JHI_W = PC_W - LIT_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t       st_d, st_q;
    pc_act_e         act;
    logic [HI_W-1:0] lat_w;
    logic [PC_W-1:0] pc_nxt;

    pgl_arbiter u_arb (
        .clr   (clr),
        .lo_wr (lo_wr),
        .jmp   (jmp),
        .act   (act)
    );

    pgl_latch #(.LAT_W(HI_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lat_we),
        .din   (lat_din),
        .q     (lat_w)
    );

    pgl_nextpc #(.PC_W(PC_W), .LO_W(LO_W), .LIT_W(LIT_W)) u_nxt (
        .act     (act),
        .pc_cur  (st_q.pc),
        .lat     (lat_w),
        .lo_add  (lo_add),
        .lo_data (lo_data),
        .tgt     (jmp_tgt),
        .pc_nxt  (pc_nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc    = st_q.pc;
    assign lat_q = lat_w;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (pc == '0)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && !$past(jmp) && !$past(lo_wr))
        |-> (pc == PC_W'($past(pc) + 1))); // R3

    AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && !$past(jmp) && $past(lo_wr))
        |-> (pc[PC_W-1:LO_W] == $past(lat_q))); // R4

    AST_LOW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && !$past(jmp) && $past(lo_wr) && !$past(lo_add))
        |-> (pc[LO_W-1:0] == $past(lo_data))); // R4

    AST_LOW_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && !$past(jmp) && $past(lo_wr) && $past(lo_add))
        |-> (pc[LO_W-1:0] == LO_W'($past(pc[LO_W-1:0]) + $past(lo_data)))); // R5

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $past(jmp))
        |-> (pc[LIT_W-1:0] == $past(jmp_tgt))); // R6

    AST_JMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $past(jmp))
        |-> (pc[PC_W-1:LIT_W] == $past(lat_q[HI_W-1 -: JHI_W]))); // R6

endmodule

// File: tb/pgpc_loader_test.sv
module pgpc_loader_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        lo_wr = 1'b0;
    logic        lo_add = 1'b0;
    logic [7:0]  lo_data = '0;
    logic        jmp = 1'b0;
    logic [10:0] jmp_tgt = '0;
    logic        lat_we = 1'b0;
    logic [4:0]  lat_din = '0;
    logic [12:0] pc;
    logic [4:0]  lat_q;

    int n_chk = 0;
    int n_fail = 0;
    int pc_m = 0;
    int lat_m = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgpc_loader uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .lo_wr   (lo_wr),
        .lo_add  (lo_add),
        .lo_data (lo_data),
        .jmp     (jmp),
        .jmp_tgt (jmp_tgt),
        .lat_we  (lat_we),
        .lat_din (lat_din),
        .pc      (pc),
        .lat_q   (lat_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Applies one cycle of inputs, advances the model, compares after the edge
    task automatic cyc(input bit c, input bit lw, input bit la, input int d,
                       input bit j, input int t, input bit we, input int ld);
        int    nxt;
        string ptag;
        string ltag;
        clr = c; lo_wr = lw; lo_add = la; lo_data = 8'(d);
        jmp = j; jmp_tgt = 11'(t); lat_we = we; lat_din = 5'(ld);
        if (c) begin
            nxt = 0; ptag = "R2";
        end else if (j) begin
            nxt = (((lat_m >> 3) & 3) << 11) | (t & 2047);
            ptag = lw ? "R7" : "R6";
            if (lw) $display("note: illegal jump+store combination driven on purpose");
        end else if (lw) begin
            nxt = ((lat_m & 31) << 8) | (la ? (((pc_m & 255) + d) & 255) : (d & 255));
            ptag = la ? "R5" : "R4";
        end else begin
            nxt = (pc_m + 1) & 8191; ptag = "R3";
        end
        ltag = we ? "R8" : "R9";
        pc_m = nxt;
        if (we) lat_m = ld & 31;
        @(posedge clk);
        @(negedge clk);
        chk(ptag, int'(pc), pc_m);
        chk(ltag, int'(lat_q), lat_m);
    endtask

    task automatic inc_n(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset with noisy inputs still clears both registers
        jmp = 1'b1; jmp_tgt = 11'h7FF; lat_we = 1'b1; lat_din = 5'h1F;
        repeat (3) @(negedge clk);
        chk("R1", int'(pc), 0);
        chk("R1", int'(lat_q), 0);
        jmp = 1'b0; lat_we = 1'b0;
        rst_n = 1'b1;

        inc_n(4);                              // R3 plain steps
        cyc(0, 0, 0, 0, 0, 0, 1, 'h15);        // R8 latch write
        cyc(0, 1, 0, 'h34, 0, 0, 0, 0);        // R4 -> 0x1534
        chk("R4", int'(pc), 'h1534);
        cyc(0, 1, 0, 'hF0, 0, 0, 0, 0);        // R4 -> 0x15F0
        cyc(0, 1, 1, 'h20, 0, 0, 0, 0);        // R5 -> 0x1510, no carry
        chk("R5", int'(pc), 'h1510);
        cyc(0, 0, 0, 0, 1, 'h5A3, 0, 0);       // R6 -> 0x15A3
        chk("R6", int'(pc), 'h15A3);
        cyc(0, 0, 0, 0, 0, 0, 1, 'h07);        // latch 00111: top bits 00
        cyc(0, 0, 0, 0, 1, 'h7FF, 0, 0);       // R6 -> 0x07FF
        chk("R6", int'(pc), 'h07FF);
        cyc(0, 1, 0, 'h99, 1, 'h123, 0, 0);    // R7 jump wins
        chk("R7", int'(pc), 'h0123);
        cyc(0, 1, 0, 'h42, 0, 0, 1, 'h1A);     // R8 store uses old latch 07
        chk("R8", int'(pc), 'h0742);
        chk("R8", int'(lat_q), 'h1A);
        cyc(1, 1, 0, 'h11, 1, 'h222, 0, 0);    // R2 clear beats all, R9 latch kept
        chk("R2", int'(pc), 0);
        chk("R9", int'(lat_q), 'h1A);
        cyc(0, 1, 0, 'hFE, 0, 0, 1, 'h00);     // R8 -> 0x1AFE, latch 0
        inc_n(3);                              // R3 carry into page: 0x1B01
        chk("R3", int'(pc), 'h1B01);
        cyc(0, 0, 0, 0, 0, 0, 1, 'h1F);
        cyc(0, 1, 0, 'hFF, 0, 0, 0, 0);        // 0x1FFF
        inc_n(1);                              // R3 top wrap
        chk("R3", int'(pc), 0);

        for (int i = 0; i < 600; i++) begin
            cyc(($urandom_range(0, 19) == 0), ($urandom_range(0, 2) == 0),
                $urandom_range(0, 1) == 1, int'($urandom_range(0, 255)),
                ($urandom_range(0, 4) == 0), int'($urandom_range(0, 2047)),
                ($urandom_range(0, 3) == 0), int'($urandom_range(0, 31)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule